// File: doc/BRIEF.md
# Bridge Error Capture and Interrupt Unit

This unit sits next to the two protocol engines of a PCI-to-AHB bridge and turns their one-cycle error pulses into sticky status bits that software can read. On the PCI side it records a received target abort, a signaled target abort and a master data parity error. On the AHB side it records a bus error. Every status bit has an enable bit. The system interrupt is a registered OR of all enabled status bits. A status bit whose enable is off still sets. It just does not raise the interrupt.

The first failing address on each side is held in a capture register. The AHB capture opens again once the AHB error bit is cleared. The PCI capture stays frozen until every PCI error bit has been cleared. A separate register bit, written only by software, drives an interrupt line out toward PCI.

Software reaches the unit through a plain register port. The port accepts a write on every cycle in which `reg_wr` is high. It never applies back-pressure and has no ready signal. Read data is combinational from `reg_addr`. The two low address bits are ignored. Event inputs are single-cycle pulses, and the address that comes with an event is only sampled in the cycle the event is high.

Top module: `bridge_err_irq`

## Requirements
- R1: After reset every register reads zero, and `sys_irq` and `pci_inta_out` are low. Word offset 0x1C (unmapped) always reads zero.
- R2: The PCI status register at 0x04 has bit0 = received target abort, bit1 = signaled target abort and bit2 = master data parity error. A pulse on the matching event input sets the bit at the next clock edge. The bit then stays set until software clears it.
- R3: Bit0 of the command register at 0x00 enables parity response. Status bit2 is set by a pulse on either `ev_rd_parity_bad` or `ev_perr_seen`, but only while that command bit is 1.
- R4: A write to a status register clears each bit whose written value is 1. Bits written with 0 do not change.
- R5: If an event and a software clear hit the same status bit in the same cycle, the bit stays set.
- R6: The interrupt status register at 0x08 has bits 2:0 as a read-only copy of PCI status bits 2:0, and bit3 as the sticky AHB error bit, cleared by writing 1. The enable register at 0x0C holds one enable per bit 3:0.
- R7: `sys_irq` goes high one cycle after any status bit and its enable bit are both 1, and falls one cycle after no such pair remains.
- R8: When the AHB error bit is clear, an AHB error loads `ev_ahb_addr` into the register at 0x10. While the AHB error bit is set, the register holds its value.
- R9: When all three PCI status bits are clear, a PCI error event loads `ev_pci_addr` into the register at 0x14. While any PCI status bit is set, the register holds its value.
- R10: Bit0 of the register at 0x18 is written by software and drives `pci_inta_out` from the next clock edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_rx_tabort | input | 1 | Pulse: target abort received as master |
| ev_tx_tabort | input | 1 | Pulse: target abort signaled as target |
| ev_rd_parity_bad | input | 1 | Pulse: bad parity seen on master read data |
| ev_perr_seen | input | 1 | Pulse: target reported a data parity error |
| ev_pci_addr | input | 32 | PCI address that goes with a PCI event |
| ev_ahb_err | input | 1 | Pulse: AHB bus error |
| ev_ahb_addr | input | 32 | AHB address that goes with the AHB error |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| sys_irq | output | 1 | Maskable system interrupt |
| pci_inta_out | output | 1 | Software-driven interrupt toward PCI |

## Verification
Two things can land on the same status bit in one cycle: a new error pulse and a write-1 clear. Another case is a new error arriving while its address capture is locked. The bench forces both on purpose, by driving the clear write and the event in the same cycle. It then checks that the bit reads back still set and that the captured address has not moved. A behavioural reference model, compared on every clock, also judges the random mix of events and writes, where such collisions happen by chance.

// File: rtl/beu_pkg.sv
package beu_pkg;
  localparam int unsigned WORD_CMD   = 0;
  localparam int unsigned WORD_PSTAT = 1;
  localparam int unsigned WORD_ISTAT = 2;
  localparam int unsigned WORD_IEN   = 3;
  localparam int unsigned WORD_AADDR = 4;
  localparam int unsigned WORD_PADDR = 5;
  localparam int unsigned WORD_MISC  = 6;
  localparam int unsigned NUM_PCI_SRC = 3;
  localparam int unsigned NUM_SRC     = NUM_PCI_SRC + 1;
endpackage

// File: rtl/beu_sticky.sv
module beu_sticky #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  // set has priority over clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= (q_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/beu_addr_cap.sv
module beu_addr_cap #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= '0;
    else if (load_i) q_o <= addr_i;
  end
endmodule

// File: rtl/beu_irq_merge.sv
module beu_irq_merge #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] stat_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic [N-1:0] hit;
  always_comb hit = stat_i & en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |hit;
  end
endmodule

// File: rtl/bridge_err_irq.sv
module bridge_err_irq
  import beu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_rx_tabort,
  input  logic              ev_tx_tabort,
  input  logic              ev_rd_parity_bad,
  input  logic              ev_perr_seen,
  input  logic [ADDR_W-1:0] ev_pci_addr,
  input  logic              ev_ahb_err,
  input  logic [ADDR_W-1:0] ev_ahb_addr,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sys_irq,
  output logic              pci_inta_out
);
  localparam int unsigned IDX_W = REG_AW - 2;
  localparam int unsigned NWORD = 1 << IDX_W;

  logic [IDX_W-1:0] widx;
  logic [NWORD-1:0] wr_hit;
  assign widx = reg_addr[REG_AW-1:2];

  genvar gi;
  generate
    for (gi = 0; gi < NWORD; gi++) begin : g_dec
      assign wr_hit[gi] = reg_wr && (widx == IDX_W'(gi));
    end
  endgenerate

  logic cmd_per;
  logic [NUM_SRC-1:0] irq_en;
  logic misc_wr;
  assign misc_wr = wr_hit[WORD_MISC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_per      <= 1'b0;
      irq_en       <= '0;
      pci_inta_out <= 1'b0;
    end else begin
      if (wr_hit[WORD_CMD]) cmd_per      <= reg_wdata[0];
      if (wr_hit[WORD_IEN]) irq_en       <= reg_wdata[NUM_SRC-1:0];
      if (misc_wr)          pci_inta_out <= reg_wdata[0];
    end
  end

  logic [NUM_PCI_SRC-1:0] pci_set, pci_clr, pci_stat;
  logic ahb_stat, ahb_clr;

  assign pci_set = {(ev_rd_parity_bad | ev_perr_seen) & cmd_per,
                    ev_tx_tabort, ev_rx_tabort};
  assign pci_clr = wr_hit[WORD_PSTAT] ? reg_wdata[NUM_PCI_SRC-1:0] : '0;
  assign ahb_clr = wr_hit[WORD_ISTAT] & reg_wdata[NUM_PCI_SRC];

  beu_sticky #(.W(NUM_PCI_SRC)) u_pci_stat (
    .clk(clk), .rst_n(rst_n), .set_i(pci_set), .clr_i(pci_clr), .q_o(pci_stat)
  );

  beu_sticky #(.W(1)) u_ahb_stat (
    .clk(clk), .rst_n(rst_n), .set_i(ev_ahb_err), .clr_i(ahb_clr), .q_o(ahb_stat)
  );

  // capture only while unlocked: AHB bit clear / all PCI bits clear
  logic ahb_load, pci_load;
  logic [ADDR_W-1:0] ahb_cap_addr, pci_cap_addr;
  assign ahb_load = ev_ahb_err & ~ahb_stat;
  assign pci_load = (|pci_set) & ~(|pci_stat);

  beu_addr_cap #(.AW(ADDR_W)) u_ahb_cap (
    .clk(clk), .rst_n(rst_n), .load_i(ahb_load), .addr_i(ev_ahb_addr), .q_o(ahb_cap_addr)
  );

  beu_addr_cap #(.AW(ADDR_W)) u_pci_cap (
    .clk(clk), .rst_n(rst_n), .load_i(pci_load), .addr_i(ev_pci_addr), .q_o(pci_cap_addr)
  );

  logic [NUM_SRC-1:0] irq_stat;
  assign irq_stat = {ahb_stat, pci_stat};

  beu_irq_merge #(.N(NUM_SRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .stat_i(irq_stat), .en_i(irq_en), .irq_o(sys_irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (widx)
      IDX_W'(WORD_CMD):   reg_rdata[0] = cmd_per;
      IDX_W'(WORD_PSTAT): reg_rdata[NUM_PCI_SRC-1:0] = pci_stat;
      IDX_W'(WORD_ISTAT): reg_rdata[NUM_SRC-1:0] = irq_stat;
      IDX_W'(WORD_IEN):   reg_rdata[NUM_SRC-1:0] = irq_en;
      IDX_W'(WORD_AADDR): reg_rdata[ADDR_W-1:0] = ahb_cap_addr;
      IDX_W'(WORD_PADDR): reg_rdata[ADDR_W-1:0] = pci_cap_addr;
      IDX_W'(WORD_MISC):  reg_rdata[0] = pci_inta_out;
      default:            reg_rdata = '0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{reg_addr[1:0], reg_wdata[DATA_W-1:NUM_SRC]};
endmodule

// File: rtl/beu_checker.sv
module beu_checker #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_ahb_err,
  input logic          ev_tx_tabort,
  input logic          cmd_per,
  input logic [2:0]    pci_stat,
  input logic          ahb_stat,
  input logic [3:0]    irq_en,
  input logic [AW-1:0] ahb_cap_addr,
  input logic [AW-1:0] pci_cap_addr,
  input logic          misc_wr,
  input logic          wdata0,
  input logic          sys_irq,
  input logic          pci_inta_out
);
  assert_ahb_addr_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ahb_stat |=> $stable(ahb_cap_addr));

  assert_pci_addr_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|pci_stat) |=> $stable(pci_cap_addr));

  assert_parity_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_per && !pci_stat[2]) |=> !pci_stat[2]);

  assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ahb_err |=> ahb_stat);

  assert_sta_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_tabort |=> pci_stat[1]);

  assert_irq_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ahb_stat && irq_en[3]) |=> sys_irq);

  assert_inta_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    misc_wr |=> (pci_inta_out == $past(wdata0)));
endmodule

bind bridge_err_irq beu_checker #(.AW(ADDR_W)) u_beu_checker (
  .clk(clk), .rst_n(rst_n), .ev_ahb_err(ev_ahb_err), .ev_tx_tabort(ev_tx_tabort),
  .cmd_per(cmd_per), .pci_stat(pci_stat), .ahb_stat(ahb_stat), .irq_en(irq_en),
  .ahb_cap_addr(ahb_cap_addr), .pci_cap_addr(pci_cap_addr), .misc_wr(misc_wr),
  .wdata0(reg_wdata[0]), .sys_irq(sys_irq), .pci_inta_out(pci_inta_out)
);

// File: tb/test_bridge_err_irq.sv
`timescale 1ns/1ps
module test_bridge_err_irq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_rx_tabort = 0, ev_tx_tabort = 0, ev_rd_parity_bad = 0, ev_perr_seen = 0, ev_ahb_err = 0;
  logic [31:0] ev_pci_addr = '0, ev_ahb_addr = '0;
  logic reg_wr = 0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic sys_irq, pci_inta_out;

  always #2.5 clk = ~clk;

  bridge_err_irq i_bridge_err_irq (
    .clk(clk), .rst_n(rst_n),
    .ev_rx_tabort(ev_rx_tabort), .ev_tx_tabort(ev_tx_tabort),
    .ev_rd_parity_bad(ev_rd_parity_bad), .ev_perr_seen(ev_perr_seen),
    .ev_pci_addr(ev_pci_addr), .ev_ahb_err(ev_ahb_err), .ev_ahb_addr(ev_ahb_addr),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sys_irq(sys_irq), .pci_inta_out(pci_inta_out)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_cmd, m_ahb, m_misc, m_irq;
  bit [2:0] m_pst;
  bit [3:0] m_en;
  bit [31:0] m_aaddr, m_paddr;

  function automatic logic [31:0] mread(input logic [4:0] a);
    case (a[4:2])
      3'd0: return {31'b0, m_cmd};
      3'd1: return {29'b0, m_pst};
      3'd2: return {28'b0, m_ahb, m_pst};
      3'd3: return {28'b0, m_en};
      3'd4: return m_aaddr;
      3'd5: return m_paddr;
      3'd6: return {31'b0, m_misc};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cmd = 0; m_ahb = 0; m_misc = 0; m_irq = 0; m_pst = 0; m_en = 0;
      m_aaddr = 0; m_paddr = 0;
    end else begin
      bit [2:0] pset, pclr;
      bit aclr, next_irq;
      next_irq = |({m_ahb, m_pst} & m_en);
      pset = {(ev_rd_parity_bad | ev_perr_seen) & m_cmd, ev_tx_tabort, ev_rx_tabort};
      pclr = (reg_wr && reg_addr[4:2] == 3'd1) ? reg_wdata[2:0] : 3'b0;
      aclr = reg_wr && reg_addr[4:2] == 3'd2 && reg_wdata[3];
      if (ev_ahb_err && !m_ahb) m_aaddr = ev_ahb_addr;
      if (pset != 0 && m_pst == 0) m_paddr = ev_pci_addr;
      m_pst = (m_pst & ~pclr) | pset;
      m_ahb = (m_ahb & !aclr) | ev_ahb_err;
      if (reg_wr && reg_addr[4:2] == 3'd0) m_cmd = reg_wdata[0];
      if (reg_wr && reg_addr[4:2] == 3'd3) m_en = reg_wdata[3:0];
      if (reg_wr && reg_addr[4:2] == 3'd6) m_misc = reg_wdata[0];
      m_irq = next_irq;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 model readback", reg_rdata, mread(reg_addr));
      chk("R7 model sys_irq", {31'b0, sys_irq}, {31'b0, m_irq});
      chk("R10 model pci_inta_out", {31'b0, pci_inta_out}, {31'b0, m_misc});
    end
  end

  // ev bits: 0 rx abort, 1 tx abort, 2 read parity, 3 perr, 4 ahb error
  task automatic cyc(input logic [4:0] ev, input logic [31:0] pa, input logic [31:0] aa,
                     input logic w, input logic [4:0] ad, input logic [31:0] wd);
    @(posedge clk); #1;
    ev_rx_tabort = ev[0]; ev_tx_tabort = ev[1]; ev_rd_parity_bad = ev[2];
    ev_perr_seen = ev[3]; ev_ahb_err = ev[4];
    ev_pci_addr = pa; ev_ahb_addr = aa;
    reg_wr = w; reg_addr = ad; reg_wdata = wd;
  endtask

  task automatic idle();
    cyc(5'b0, 32'h0, 32'h0, 1'b0, reg_addr, 32'h0);
  endtask

  task automatic wr(input logic [4:0] ad, input logic [31:0] wd);
    cyc(5'b0, 32'h0, 32'h0, 1'b1, ad, wd);
  endtask

  task automatic ev(input logic [4:0] e, input logic [31:0] pa, input logic [31:0] aa);
    cyc(e, pa, aa, 1'b0, reg_addr, 32'h0);
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] ad, input logic [31:0] exp);
    cyc(5'b0, 32'h0, 32'h0, 1'b0, ad, 32'h0);
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 8; a++) rd_chk("R1 reset read", 5'(a * 4), 32'h0);
    chk("R1 sys_irq low", {31'b0, sys_irq}, 32'h0);
    chk("R1 pci_inta_out low", {31'b0, pci_inta_out}, 32'h0);

    // R2 / R9 set and capture
    ev(5'b00001, 32'hA000_0001, 0);
    rd_chk("R2 rx abort bit0", 5'h04, 32'h1);
    rd_chk("R9 first pci capture", 5'h14, 32'hA000_0001);
    ev(5'b00010, 32'hA000_0002, 0);
    rd_chk("R2 tx abort bit1", 5'h04, 32'h3);
    rd_chk("R9 pci address locked", 5'h14, 32'hA000_0001);

    // R3 parity gating
    ev(5'b00100, 32'hA000_0003, 0);
    rd_chk("R3 parity masked by cmd", 5'h04, 32'h3);
    wr(5'h00, 32'h1);
    ev(5'b01000, 32'hA000_0004, 0);
    rd_chk("R3 perr sets bit2", 5'h04, 32'h7);

    // R4 write-one-to-clear
    wr(5'h04, 32'h0);
    rd_chk("R4 write zero no effect", 5'h04, 32'h7);
    wr(5'h04, 32'h1);
    rd_chk("R4 clear bit0", 5'h04, 32'h6);
    ev(5'b00001, 32'hA000_0005, 0);
    rd_chk("R9 locked while any bit set", 5'h14, 32'hA000_0001);
    wr(5'h04, 32'h7);
    rd_chk("R4 clear all", 5'h04, 32'h0);
    ev(5'b00010, 32'hA000_0006, 0);
    rd_chk("R9 recapture after clear", 5'h14, 32'hA000_0006);

    // R6 mirror is read-only
    rd_chk("R6 istat mirrors pci", 5'h08, 32'h2);
    wr(5'h08, 32'h7);
    rd_chk("R6 istat write leaves pci", 5'h04, 32'h2);

    // R8 AHB capture
    ev(5'b10000, 0, 32'hB000_0001);
    rd_chk("R6 ahb bit3", 5'h08, 32'hA);
    rd_chk("R8 first ahb capture", 5'h10, 32'hB000_0001);
    ev(5'b10000, 0, 32'hB000_0002);
    rd_chk("R8 ahb address locked", 5'h10, 32'hB000_0001);
    wr(5'h08, 32'h8);
    rd_chk("R4 ahb bit cleared", 5'h08, 32'h2);
    ev(5'b10000, 0, 32'hB000_0003);
    rd_chk("R8 recapture after clear", 5'h10, 32'hB000_0003);

    // R7 masking and latency
    @(negedge clk);
    chk("R7 masked stays low", {31'b0, sys_irq}, 32'h0);
    wr(5'h0C, 32'h8);
    idle(); @(negedge clk);
    chk("R7 latency not yet", {31'b0, sys_irq}, 32'h0);
    idle(); @(negedge clk);
    chk("R7 irq raised", {31'b0, sys_irq}, 32'h1);
    wr(5'h08, 32'h8);
    idle(); idle(); @(negedge clk);
    chk("R7 irq dropped", {31'b0, sys_irq}, 32'h0);

    // R5 event beats clear
    ev(5'b10000, 0, 32'hB000_0004);
    cyc(5'b10000, 0, 32'hB000_0005, 1'b1, 5'h08, 32'h8);
    rd_chk("R5 ahb bit stays set", 5'h08, 32'hA);
    rd_chk("R5 ahb address unchanged", 5'h10, 32'hB000_0004);
    cyc(5'b00010, 32'hA000_0007, 0, 1'b1, 5'h04, 32'h2);
    rd_chk("R5 pci bit stays set", 5'h04, 32'h2);
    rd_chk("R5 pci address unchanged", 5'h14, 32'hA000_0006);

    // R10 outbound line
    wr(5'h18, 32'h1);
    idle(); @(negedge clk);
    chk("R10 inta high", {31'b0, pci_inta_out}, 32'h1);
    wr(5'h18, 32'h0);
    idle(); @(negedge clk);
    chk("R10 inta low", {31'b0, pci_inta_out}, 32'h0);
    rd_chk("R1 unmapped reads zero", 5'h1C, 32'h0);

    // random mix, judged by the model each clock
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] e;
      logic w;
      e = 5'($urandom) & 5'($urandom) & 5'($urandom);
      w = ($urandom % 4) == 0;
      cyc(e, $urandom, $urandom, w, 5'($urandom), $urandom);
    end
    idle(); idle();
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule